// File: doc/BRIEF.md
# Page-Mode External Fetch Sequencer

This block sequences the bus cycles of a microcontroller's external memory interface. The core presents one request at a time: an address, a cycle kind and, for sequential code, the knowledge of whether program flow just jumped. The block turns that request into bus states on two byte-wide ports plus an upper address byte, an address-latch strobe and active-low read and write strobes. It answers with a one-cycle done strobe and, for reads, the byte it captured.

When page mode is on, the block remembers the 256-byte page of the last external code fetch. A code fetch that lands in that page skips the address-latch state and completes in a single bus state. Any event that breaks sequential fetching forces the next fetch back to the full two-state form and rebuilds the page record: a jump, a data cycle, a wake from low power, or leaving page mode. In page mode the low address byte sits alone on port 0, and port 2 carries address bits 15:8 and then the data. With page mode off, port 0 multiplexes the low address byte with the data, and port 2 holds bits 15:8 for the whole cycle.

Top module: `pgfetch_seq`

## Requirements
- R1: After reset, done_o is 0, ale_o is 0, rd_n_o and wr_n_o are 1, and the first external code fetch takes the two-state form even in page mode.
- R2: Cycle kind is encoded on kind_i as 0 = external code fetch, 1 = data read, 2 = data write, 3 = internal code fetch. A request is taken on the clock edge where req_i is 1 and the block is idle. That edge counts as edge 1. done_o is then visible after edge 2 for a page hit, after edge 3 for a two-state fetch or a data read, after edge 4 for a data write, and after edge 1 for an internal fetch.
- R3: With page mode on, an external code fetch is a page hit only if address bits 23:8 equal those of the most recent two-state external code fetch. A fetch to any other page takes the two-state form, and the fetches after it in the new page are hits.
- R4: A fetch whose sequential address crosses from offset 0xFF of one page to offset 0x00 of the next is a miss.
- R5: The first external code fetch after a data read or data write is a miss.
- R6: The first external code fetch after a one-cycle wake_i pulse is a miss, even when the pulse arrives while the block is idle.
- R7: A code fetch presented with nonseq_i = 1 is a miss.
- R8: An internal code fetch produces no ALE, RD# or WR# activity and leaves page tracking intact, so a following fetch to the tracked page is still a hit.
- R9: In page mode, during the ALE state port 0 drives A7:0, port 2 drives A15:8 and ahi_o drives A23:16. While rd_n_o is low, port 0 still drives A7:0, port 2 is released, and rdata_o takes the byte from p2_i.
- R10: With page mode off, every code fetch takes the two-state form. While rd_n_o is low, port 0 is released, port 2 keeps driving A15:8, and rdata_o takes the byte from p0_i.
- R11: A data write uses three states: ALE, then WR# low with the data driven, then WR# high with the data still driven. The data goes on port 2 in page mode and on port 0 otherwise.
- R12: ALE is high for exactly one state, only in two- and three-state cycles, never in a hit. rd_n_o and wr_n_o are never low together. All strobes are inactive while no request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request, taken when the block is idle |
| kind_i | input | 2 | Cycle kind: 0 code, 1 data read, 2 data write, 3 internal code |
| addr_i | input | 24 | Request address |
| wdata_i | input | 8 | Write data |
| nonseq_i | input | 1 | Request follows a change of program flow |
| wake_i | input | 1 | One-cycle pulse on exit from a low-power mode |
| page_en_i | input | 1 | Page mode enable |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 8 | Captured read byte |
| p0_o | output | 8 | Port 0 output value |
| p0_oe_o | output | 1 | Port 0 output enable |
| p0_i | input | 8 | Port 0 input value |
| p2_o | output | 8 | Port 2 output value |
| p2_oe_o | output | 1 | Port 2 output enable |
| p2_i | input | 8 | Port 2 input value |
| ahi_o | output | 8 | Address bits 23:16 |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with its default parameters: a 24-bit address and a 256-byte page. At this size the page record is 16 bits wide, so a rollover such as 0x1234FF to 0x123500 and a jump to a distant page like 0x777777 both fall within a short run. The reads give different bytes on the two ports, so a capture from the wrong port for the current mode shows up as a data mismatch. The run switches page mode off and back on mid-stream, which reaches the path where leaving page mode clears the page record.

// File: rtl/pgfetch_pkg.sv
`timescale 1ns/1ps
package pgfetch_pkg;
  typedef enum logic [1:0] {
    K_CODE = 2'b00,
    K_DRD  = 2'b01,
    K_DWR  = 2'b10,
    K_INT  = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_DATA,
    S_HOLD,
    S_HIT
  } st_e;
endpackage

// File: rtl/pgfetch_track.sv
`timescale 1ns/1ps
module pgfetch_track
  import pgfetch_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  kind_e             kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              nonseq_i,
  input  logic              wake_i,
  input  logic              page_en_i,
  output logic              hit_o
);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0] tag_q;
  logic             vld_q;
  logic             tag_eq;
  logic             is_data;

  assign tag_eq  = (addr_i[ADDR_W-1:OFF_W] == tag_q);
  assign is_data = (kind_i == K_DRD) || (kind_i == K_DWR);
  // A rollover changes the page bits, so it fails tag_eq and is a miss.
  assign hit_o   = page_en_i && vld_q && tag_eq && !nonseq_i && !wake_i
                   && (kind_i == K_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
      vld_q <= 1'b0;
    end else if (accept_i && kind_i == K_CODE && page_en_i) begin
      if (!hit_o) begin
        tag_q <= addr_i[ADDR_W-1:OFF_W];
        vld_q <= 1'b1;
      end
    end else if (accept_i && is_data) begin
      vld_q <= 1'b0;
    end else if (wake_i || !page_en_i) begin
      vld_q <= 1'b0;
    end
  end

  // R5: a data cycle drops the page record
  a_r5_data_clears: assert property (@(posedge clk) disable iff (rst)
    (accept_i && is_data) |=> !vld_q);

  // R6: a wake pulse drops the page record unless a new miss reloads it
  a_r6_wake_clears: assert property (@(posedge clk) disable iff (rst)
    (wake_i && !(accept_i && kind_i == K_CODE && page_en_i)) |=> !vld_q);
endmodule

// File: rtl/pgfetch_bus.sv
`timescale 1ns/1ps
module pgfetch_bus
  import pgfetch_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  kind_e             kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              page_en_i,
  input  logic              hit_i,
  input  logic [BYTE_W-1:0] p0_i,
  input  logic [BYTE_W-1:0] p2_i,
  output logic              accept_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] p0_o,
  output logic              p0_oe_o,
  output logic [BYTE_W-1:0] p2_o,
  output logic              p2_oe_o,
  output logic [ADDR_W-2*BYTE_W-1:0] ahi_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  localparam int HI_LSB = 2 * BYTE_W;

  st_e               st_q;
  kind_e             kind_q;
  logic [BYTE_W-1:0] wd_q;
  logic              pm_q;

  assign accept_o = req_i && (st_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      kind_q  <= K_CODE;
      wd_q    <= '0;
      pm_q    <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
      p0_o    <= '0;
      p0_oe_o <= 1'b0;
      p2_o    <= '0;
      p2_oe_o <= 1'b0;
      ahi_o   <= '0;
      ale_o   <= 1'b0;
      rd_n_o  <= 1'b1;
      wr_n_o  <= 1'b1;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (req_i) begin
            kind_q <= kind_i;
            wd_q   <= wdata_i;
            pm_q   <= page_en_i;
            if (kind_i == K_INT) begin
              done_o <= 1'b1;
            end else if (hit_i) begin
              st_q    <= S_HIT;
              rd_n_o  <= 1'b0;
              p0_o    <= addr_i[BYTE_W-1:0];
              p0_oe_o <= 1'b1;
              p2_oe_o <= 1'b0;
              ahi_o   <= addr_i[ADDR_W-1:HI_LSB];
            end else begin
              st_q    <= S_ADDR;
              ale_o   <= 1'b1;
              p0_o    <= addr_i[BYTE_W-1:0];
              p0_oe_o <= 1'b1;
              p2_o    <= addr_i[HI_LSB-1:BYTE_W];
              p2_oe_o <= 1'b1;
              ahi_o   <= addr_i[ADDR_W-1:HI_LSB];
            end
          end
        end
        S_HIT: begin
          rdata_o <= p2_i;
          done_o  <= 1'b1;
          rd_n_o  <= 1'b1;
          p0_oe_o <= 1'b0;
          st_q    <= S_IDLE;
        end
        S_ADDR: begin
          ale_o <= 1'b0;
          st_q  <= S_DATA;
          if (kind_q == K_DWR) begin
            wr_n_o <= 1'b0;
            if (pm_q) p2_o <= wd_q;
            else      p0_o <= wd_q;
          end else begin
            rd_n_o <= 1'b0;
            if (pm_q) p2_oe_o <= 1'b0;
            else      p0_oe_o <= 1'b0;
          end
        end
        S_DATA: begin
          if (kind_q == K_DWR) begin
            wr_n_o <= 1'b1;
            st_q   <= S_HOLD;
          end else begin
            rdata_o <= pm_q ? p2_i : p0_i;
            rd_n_o  <= 1'b1;
            done_o  <= 1'b1;
            p0_oe_o <= 1'b0;
            p2_oe_o <= 1'b0;
            st_q    <= S_IDLE;
          end
        end
        S_HOLD: begin
          done_o  <= 1'b1;
          p0_oe_o <= 1'b0;
          p2_oe_o <= 1'b0;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R12: strobes never overlap
  a_r12_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n_o && !wr_n_o));

  // R12: ALE lasts one state
  a_r12_ale_single: assert property (@(posedge clk) disable iff (rst)
    $rose(ale_o) |=> !ale_o);

  // R2: a hit state ends with done on the next edge
  a_r2_hit_done: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_HIT) |=> (done_o && rd_n_o));

  // R11: WR# low one state, then a hold state, then done
  a_r11_write_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n_o) |=> (wr_n_o && !done_o) ##1 done_o);

  // R8: internal fetch completes without bus strobes
  a_r8_internal: assert property (@(posedge clk) disable iff (rst)
    (accept_o && kind_i == K_INT) |=> (done_o && !ale_o && rd_n_o && wr_n_o));
endmodule

// File: rtl/pgfetch_seq.sv
`timescale 1ns/1ps
module pgfetch_seq
  import pgfetch_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8,
  parameter int OFF_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_i,
  input  logic [1:0]                 kind_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [BYTE_W-1:0]          wdata_i,
  input  logic                       nonseq_i,
  input  logic                       wake_i,
  input  logic                       page_en_i,
  output logic                       done_o,
  output logic [BYTE_W-1:0]          rdata_o,
  output logic [BYTE_W-1:0]          p0_o,
  output logic                       p0_oe_o,
  input  logic [BYTE_W-1:0]          p0_i,
  output logic [BYTE_W-1:0]          p2_o,
  output logic                       p2_oe_o,
  input  logic [BYTE_W-1:0]          p2_i,
  output logic [ADDR_W-2*BYTE_W-1:0] ahi_o,
  output logic                       ale_o,
  output logic                       rd_n_o,
  output logic                       wr_n_o
);
  kind_e kind_w;
  logic  accept_w;
  logic  hit_w;

  assign kind_w = kind_e'(kind_i);

  pgfetch_track #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) track_i (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (accept_w),
    .kind_i    (kind_w),
    .addr_i    (addr_i),
    .nonseq_i  (nonseq_i),
    .wake_i    (wake_i),
    .page_en_i (page_en_i),
    .hit_o     (hit_w)
  );

  pgfetch_bus #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) bus_i (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .kind_i    (kind_w),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .page_en_i (page_en_i),
    .hit_i     (hit_w),
    .p0_i      (p0_i),
    .p2_i      (p2_i),
    .accept_o  (accept_w),
    .done_o    (done_o),
    .rdata_o   (rdata_o),
    .p0_o      (p0_o),
    .p0_oe_o   (p0_oe_o),
    .p2_o      (p2_o),
    .p2_oe_o   (p2_oe_o),
    .ahi_o     (ahi_o),
    .ale_o     (ale_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o)
  );

  // R7: a flow change never yields a one-state fetch
  a_r7_nonseq_miss: assert property (@(posedge clk) disable iff (rst)
    (accept_w && nonseq_i && kind_w == K_CODE) |=> ale_o);

  // R10: page mode off forces the two-state form for code
  a_r10_nopage_two_state: assert property (@(posedge clk) disable iff (rst)
    (accept_w && !page_en_i && kind_w == K_CODE) |=> (ale_o && rd_n_o));
endmodule

// File: tb/pgfetch_seq_tb_top.sv
`timescale 1ns/1ps
module pgfetch_seq_tb_top;
  import pgfetch_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  kind = 2'b00;
  logic [23:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        nonseq = 1'b0;
  logic        wake = 1'b0;
  logic        page_en = 1'b1;
  logic [7:0]  p0_in = '0;
  logic [7:0]  p2_in = '0;
  logic        done_o, p0_oe_o, p2_oe_o, ale_o, rd_n_o, wr_n_o;
  logic [7:0]  rdata_o, p0_o, p2_o, ahi_o;

  always #2.5 clk = ~clk;

  pgfetch_seq dut_i (
    .clk(clk), .rst(rst), .req_i(req), .kind_i(kind), .addr_i(addr),
    .wdata_i(wdata), .nonseq_i(nonseq), .wake_i(wake), .page_en_i(page_en),
    .done_o(done_o), .rdata_o(rdata_o), .p0_o(p0_o), .p0_oe_o(p0_oe_o),
    .p0_i(p0_in), .p2_o(p2_o), .p2_oe_o(p2_oe_o), .p2_i(p2_in),
    .ahi_o(ahi_o), .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o)
  );

  typedef struct {
    logic [23:0] addr;
    int          lat;
    int          ale;
    logic [7:0]  data;
    bit          rd;
    bit          pm;
    string       req;
  } exp_t;

  exp_t q[$];
  bit   in_flight = 1'b0;
  int   n_chk = 0;
  int   n_err = 0;
  int   lat_cnt = 0;
  int   ale_cnt = 0;
  bit   finished = 1'b0;

  task automatic check(bit ok, string r, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // Driver: presents one request and pushes what the monitor must see.
  task automatic issue(kind_e k, logic [23:0] a, bit ns, logic [7:0] d,
                       int lat, string r);
    exp_t e;
    e.addr = a;
    e.lat  = lat;
    e.ale  = (lat <= 2) ? 0 : 1;
    e.data = d;
    e.rd   = (k == K_CODE) || (k == K_DRD);
    e.pm   = page_en;
    e.req  = r;
    @(negedge clk);
    kind   = k;
    addr   = a;
    nonseq = ns;
    wdata  = d;
    if (page_en) begin p2_in = d; p0_in = ~d; end
    else         begin p0_in = d; p2_in = ~d; end
    req = 1'b1;
    q.push_back(e);
    @(posedge clk);
    in_flight = 1'b1;
    @(negedge clk);
    req    = 1'b0;
    nonseq = 1'b0;
    wait (!in_flight);
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  // Monitor: compares the bus and the completion against the queue head.
  always @(negedge clk) begin
    exp_t e;
    if (!rst && !finished) begin
      check(!(!rd_n_o && !wr_n_o), "R12", "dual strobe", {rd_n_o, wr_n_o}, 2'b11);
      if (in_flight) begin
        e = q[0];
        lat_cnt++;
        if (ale_o) begin
          ale_cnt++;
          check(p0_o == e.addr[7:0], "R9", "ale p0", p0_o, e.addr[7:0]);
          check(p2_o == e.addr[15:8] && p2_oe_o, "R9", "ale p2", p2_o, e.addr[15:8]);
          check(ahi_o == e.addr[23:16], "R9", "ale ahi", ahi_o, e.addr[23:16]);
        end
        if (!rd_n_o) begin
          if (e.pm)
            check(!p2_oe_o && p0_oe_o && p0_o == e.addr[7:0], "R9",
                  "read phase p0", p0_o, e.addr[7:0]);
          else
            check(!p0_oe_o && p2_oe_o && p2_o == e.addr[15:8], "R10",
                  "read phase p2", p2_o, e.addr[15:8]);
        end
        if (!wr_n_o) begin
          if (e.pm) check(p2_oe_o && p2_o == e.data, "R11", "write p2", p2_o, e.data);
          else      check(p0_oe_o && p0_o == e.data, "R11", "write p0", p0_o, e.data);
        end
        if (done_o) begin
          check(lat_cnt == e.lat, e.req, "latency", lat_cnt, e.lat);
          check(ale_cnt == e.ale, "R12", "ale count", ale_cnt, e.ale);
          if (e.rd) check(rdata_o == e.data, e.req, "rdata", rdata_o, e.data);
          void'(q.pop_front());
          lat_cnt   = 0;
          ale_cnt   = 0;
          in_flight = 1'b0;
        end
      end else begin
        check(!done_o && !ale_o && rd_n_o && wr_n_o, "R12", "idle strobes",
              {done_o, ale_o, rd_n_o, wr_n_o}, 4'b0011);
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(!done_o && !ale_o && rd_n_o && wr_n_o, "R1", "reset outputs",
          {done_o, ale_o, rd_n_o, wr_n_o}, 4'b0011);
    issue(K_CODE, 24'h123400, 0, 8'h11, 3, "R1");
    issue(K_CODE, 24'h123401, 0, 8'h22, 2, "R2");
    issue(K_CODE, 24'h1234FF, 0, 8'h33, 2, "R2");
    issue(K_CODE, 24'h123500, 0, 8'h44, 3, "R4");
    issue(K_CODE, 24'h123501, 0, 8'h55, 2, "R3");
    issue(K_INT,  24'h000010, 0, 8'h00, 1, "R8");
    issue(K_CODE, 24'h123502, 0, 8'h66, 2, "R8");
    issue(K_CODE, 24'h777777, 0, 8'h77, 3, "R3");
    issue(K_CODE, 24'h777778, 0, 8'h88, 2, "R3");
    issue(K_DRD,  24'h777779, 0, 8'h99, 3, "R9");
    issue(K_CODE, 24'h77777A, 0, 8'hAA, 3, "R5");
    issue(K_CODE, 24'h77777B, 0, 8'hBB, 2, "R2");
    issue(K_DWR,  24'h005555, 0, 8'hA5, 4, "R11");
    issue(K_CODE, 24'h77777C, 0, 8'hCC, 3, "R5");
    pulse_wake();
    issue(K_CODE, 24'h77777D, 0, 8'hDD, 3, "R6");
    issue(K_CODE, 24'h77777E, 0, 8'hEE, 2, "R6");
    issue(K_CODE, 24'h77777F, 1, 8'hF0, 3, "R7");
    issue(K_CODE, 24'h777780, 0, 8'hF1, 2, "R7");
    page_en = 1'b0;
    issue(K_CODE, 24'h777781, 0, 8'h12, 3, "R10");
    issue(K_CODE, 24'h777782, 0, 8'h13, 3, "R10");
    issue(K_DRD,  24'h00ABCD, 0, 8'h14, 3, "R10");
    issue(K_DWR,  24'h00ABCE, 0, 8'h5A, 4, "R11");
    page_en = 1'b1;
    issue(K_CODE, 24'h777783, 0, 8'h15, 3, "R10");
    issue(K_CODE, 24'h777784, 0, 8'h16, 2, "R2");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule